// File: doc/BRIEF.md
# Vectored Interrupt Controller with Pending Latches

This block arbitrates interrupt requests for a small 8-bit CPU core. It serves five vectors, numbered 0 to 4. Vector 0 belongs to a non-maskable pin. Vectors 1 to 4 are maskable:

- Vectors 1 and 2 receive events from two groups of port pins.
- Vector 3 receives the timer-zero source.
- Vector 4 receives the converter end-of-conversion source.

Each pin passes through a two-flop synchronizer and then an edge detector. The resulting events are held in pending latches, even while the global enable is clear. The hardware clears a latch when the core enters the matching vector routine.

Three control bits steer the maskable sources:

- A global enable gates all maskable sources.
- An edge-select bit picks the active edge for the port pins.
- A steering bit routes the first port group to vector 1 or to vector 2.

Toward the core, the block raises a request and presents the winning vector number and its fixed program-counter address. The same request also drives a wake line that ends stop or wait mode. The core accepts the request with an acknowledge pulse. The block then marks a routine as in service until the core returns a return pulse. Several events may share one vector. The peripheral flag, not this block, tells which one fired.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, irq_req and wake are 0 and no vector is pending.
- R2: A falling edge on nmi_n latches vector 0, and vector 0 is requested whatever gen_en is or whether a maskable routine is in service. A rising edge on nmi_n latches nothing.
- R3: Port pin events are latched while gen_en is 0 and produce no request until gen_en is 1. From then on they are requested without any new edge.
- R4: With edge_rise at 0, only falling pin edges set a port latch. With edge_rise at 1, only rising pin edges set it. The opposite edge has no effect.
- R5: An event on any grpa_pin bit goes to vector 1 when port_to_v2 is 0 and to vector 2 when port_to_v2 is 1. An event on any grpb_pin bit always goes to vector 2.
- R6: Vector 3 is requested only while tmr_zero and tmr_ie are both 1. Vector 4 is requested only while adc_eoc and adc_ie are both 1. Both are level sources gated by gen_en.
- R7: When several vectors are eligible, the lowest vector number wins. vec_id shows the number of the winner.
- R8: An accepted request (irq_ack while irq_req) clears the latch of vector 0, 1 or 2, whichever was granted. Vectors 3 and 4 are not cleared by the controller and stay requested while their flag and enable remain 1.
- R9: After a maskable vector is accepted, no maskable vector is requested until irq_ret. After vector 0 is accepted, nothing is requested until irq_ret. irq_ret ends the non-maskable service first if that service is active.
- R10: vec_addr equals VEC_TOP minus vec_id times VEC_STEP. With the default values, vectors 0 to 4 map to 0xFFC, 0xFFA, 0xFF8, 0xFF6 and 0xFF4.
- R11: wake is 1 exactly when irq_req is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_n | input | 1 | Non-maskable request pin, falling edge active |
| grpa_pin | input | PA_W | First port pin group |
| grpb_pin | input | PB_W | Second port pin group |
| tmr_zero | input | 1 | Timer reached-zero flag |
| tmr_ie | input | 1 | Timer interrupt enable |
| adc_eoc | input | 1 | Converter end-of-conversion flag |
| adc_ie | input | 1 | Converter interrupt enable |
| gen_en | input | 1 | Global maskable enable |
| edge_rise | input | 1 | Port edge select: 1 rising, 0 falling |
| port_to_v2 | input | 1 | Route first port group to vector 2 |
| irq_ack | input | 1 | Core accepts the presented vector |
| irq_ret | input | 1 | Core returns from a routine |
| irq_req | output | 1 | Interrupt request to the core |
| vec_id | output | 3 | Number of the presented vector |
| vec_addr | output | ADDR_W | Program counter load address |
| wake | output | 1 | Leave stop or wait mode |

## Verification
The assertions take for granted that the core pulses irq_ack only while irq_req is high, and never in the same cycle as irq_ret. They also assume the pins are held at their reset level through reset, so the synchronizers do not see a false edge. The stimulus follows these rules. Every acknowledge is a single-cycle pulse driven while a request is shown, and every return comes in a later cycle. Port pins stay low and nmi_n stays high during and after reset until a test deliberately moves them. Each pin is held for several cycles, so every edge passes the synchronizer before the bench samples.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
   localparam int VEC_N = 5;
   localparam int VID_W = $clog2(VEC_N);
   typedef logic [VID_W-1:0] vec_id_t;
   localparam vec_id_t VID_NMI = vec_id_t'(0);
   localparam vec_id_t VID_PA  = vec_id_t'(1);
   localparam vec_id_t VID_PB  = vec_id_t'(2);
   localparam vec_id_t VID_TMR = vec_id_t'(3);
   localparam vec_id_t VID_ADC = vec_id_t'(4);
   localparam int LATCHED_N = 3;  // vectors 0..2 own a pending latch
endpackage

// File: rtl/irqv_edge_det.sv
module irqv_edge_det #(
   parameter int W         = 4,
   parameter bit RST_VAL   = 1'b0,
   parameter bit FIXED_FALL = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pins,
   input  logic         rise,
   output logic         evt
);
   logic [W-1:0] s1, s2, s3;

   initial begin : elab_chk
      assert (W >= 1) else $error("irqv_edge_det: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1 <= {W{RST_VAL}};
         s2 <= {W{RST_VAL}};
         s3 <= {W{RST_VAL}};
      end else begin
         s1 <= pins;
         s2 <= s1;
         s3 <= s2;
      end
   end

   generate
      if (FIXED_FALL) begin : g_fall
         logic unused_rise;
         assign unused_rise = rise;
         assign evt = |(~s2 & s3);
      end else begin : g_sel
         assign evt = rise ? |(s2 & ~s3) : |(~s2 & s3);
      end
   endgenerate
endmodule

// File: rtl/irqv_prio.sv
module irqv_prio #(
   parameter int N  = 5,
   parameter int IW = $clog2(N)
) (
   input  logic [N-1:0]  req,
   output logic [N-1:0]  grant,
   output logic          any,
   output logic [IW-1:0] idx
);
   initial begin : elab_chk
      assert (N >= 2 && (1 << IW) >= N) else $error("irqv_prio: bad N/IW");
   end

   generate
      for (genvar i = 0; i < N; i++) begin : g_pr
         if (i == 0) begin : g_first
            assign grant[i] = req[i];
         end else begin : g_rest
            assign grant[i] = req[i] & ~|req[i-1:0];
         end
      end
   endgenerate

   assign any = |req;

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (grant[i]) idx = IW'(i);
      end
   end

   always_comb begin
      p_grant_onehot_r7: assert ($onehot0(grant));
      p_grant_any_r7: assert (any == (grant != '0));
   end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
   import irqv_pkg::*;
#(
   parameter int PA_W     = 4,
   parameter int PB_W     = 8,
   parameter int ADDR_W   = 12,
   parameter int VEC_TOP  = 'hFFC,
   parameter int VEC_STEP = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              nmi_n,
   input  logic [PA_W-1:0]   grpa_pin,
   input  logic [PB_W-1:0]   grpb_pin,
   input  logic              tmr_zero,
   input  logic              tmr_ie,
   input  logic              adc_eoc,
   input  logic              adc_ie,
   input  logic              gen_en,
   input  logic              edge_rise,
   input  logic              port_to_v2,
   input  logic              irq_ack,
   input  logic              irq_ret,
   output logic              irq_req,
   output logic [VID_W-1:0]  vec_id,
   output logic [ADDR_W-1:0] vec_addr,
   output logic              wake
);
   initial begin : elab_chk
      assert (PA_W >= 1 && PB_W >= 1) else $error("irq_vector_ctrl: empty pin group");
      assert (VEC_STEP > 0 && VEC_TOP >= (VEC_N - 1) * VEC_STEP && VEC_TOP < (1 << ADDR_W))
         else $error("irq_vector_ctrl: vector table does not fit ADDR_W");
   end

   logic                 evt_n, evt_a, evt_b;
   logic [LATCHED_N-1:0] set_v, clr_v, lat;
   logic [VEC_N-1:0]     req;
   logic                 svc_n, svc_m, mask_ok, take, any;
   vec_id_t              win;

   irqv_edge_det #(.W(1), .RST_VAL(1'b1), .FIXED_FALL(1'b1)) u_nmi (
      .clk(clk), .rst_n(rst_n), .pins(nmi_n), .rise(1'b0), .evt(evt_n));
   irqv_edge_det #(.W(PA_W), .RST_VAL(1'b0), .FIXED_FALL(1'b0)) u_pa (
      .clk(clk), .rst_n(rst_n), .pins(grpa_pin), .rise(edge_rise), .evt(evt_a));
   irqv_edge_det #(.W(PB_W), .RST_VAL(1'b0), .FIXED_FALL(1'b0)) u_pb (
      .clk(clk), .rst_n(rst_n), .pins(grpb_pin), .rise(edge_rise), .evt(evt_b));

   assign set_v[VID_NMI] = evt_n;
   assign set_v[VID_PA]  = evt_a & ~port_to_v2;
   assign set_v[VID_PB]  = (evt_a & port_to_v2) | evt_b;

   assign take = irq_ack & any;

   generate
      for (genvar i = 0; i < LATCHED_N; i++) begin : g_lat
         assign clr_v[i] = take && (win == vec_id_t'(i));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lat[i] <= 1'b0;
            else        lat[i] <= set_v[i] | (lat[i] & ~clr_v[i]);
         end
      end
   endgenerate

   assign mask_ok      = gen_en & ~svc_m & ~svc_n;
   assign req[VID_NMI] = lat[VID_NMI] & ~svc_n;
   assign req[VID_PA]  = lat[VID_PA] & mask_ok;
   assign req[VID_PB]  = lat[VID_PB] & mask_ok;
   assign req[VID_TMR] = tmr_zero & tmr_ie & mask_ok;
   assign req[VID_ADC] = adc_eoc & adc_ie & mask_ok;

   logic [VEC_N-1:0] grant;
   irqv_prio #(.N(VEC_N), .IW(VID_W)) u_prio (
      .req(req), .grant(grant), .any(any), .idx(win));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         svc_n <= 1'b0;
         svc_m <= 1'b0;
      end else if (take) begin
         if (win == VID_NMI) svc_n <= 1'b1;
         else                svc_m <= 1'b1;
      end else if (irq_ret) begin
         if (svc_n) svc_n <= 1'b0;
         else       svc_m <= 1'b0;
      end
   end

   function automatic logic [ADDR_W-1:0] vec_address(input vec_id_t id);
      return ADDR_W'(VEC_TOP - int'(id) * VEC_STEP);
   endfunction

   assign irq_req  = any;
   assign vec_id   = win;
   assign vec_addr = vec_address(win);
   assign wake     = any;

   p_mask_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && vec_id != VID_NMI) |-> gen_en);
   p_svc_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
      svc_m |-> !(irq_req && vec_id != VID_NMI));
   p_ack_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (take && win == VID_PA && !set_v[VID_PA]) |=> !lat[VID_PA]);
   p_nmi_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (lat[VID_NMI] && !svc_n) |-> (irq_req && vec_id == VID_NMI));
   p_latch_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (lat[VID_PB] && !clr_v[VID_PB]) |=> lat[VID_PB]);
endmodule

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;
   localparam int PA_W = 2;
   localparam int PB_W = 2;
   localparam int AW   = 12;

   logic clk = 1'b0;
   logic rst_n;
   logic nmi_n;
   logic [PA_W-1:0] grpa_pin;
   logic [PB_W-1:0] grpb_pin;
   logic tmr_zero, tmr_ie, adc_eoc, adc_ie, gen_en, edge_rise, port_to_v2, irq_ack, irq_ret;
   logic irq_req, wake;
   logic [2:0] vec_id;
   logic [AW-1:0] vec_addr;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   irq_vector_ctrl #(.PA_W(PA_W), .PB_W(PB_W), .ADDR_W(AW), .VEC_TOP('hFFC), .VEC_STEP(2)) dut (
      .clk(clk), .rst_n(rst_n), .nmi_n(nmi_n), .grpa_pin(grpa_pin), .grpb_pin(grpb_pin),
      .tmr_zero(tmr_zero), .tmr_ie(tmr_ie), .adc_eoc(adc_eoc), .adc_ie(adc_ie),
      .gen_en(gen_en), .edge_rise(edge_rise), .port_to_v2(port_to_v2),
      .irq_ack(irq_ack), .irq_ret(irq_ret), .irq_req(irq_req), .vec_id(vec_id),
      .vec_addr(vec_addr), .wake(wake));

   task automatic chk(input string rq, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", rq, act, exp, $time);
      end
   endtask

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   // expected request state; address computed from the vector number (R10)
   task automatic expect_req(input string rq, input bit exp_req, input int exp_id);
      chk({rq, " irq_req"}, int'(irq_req), int'(exp_req));
      chk({rq, " wake R11"}, int'(wake), int'(exp_req));
      if (exp_req) begin
         chk({rq, " vec_id"}, int'(vec_id), exp_id);
         chk({rq, " vec_addr R10"}, int'(vec_addr), 'hFFC - 2 * exp_id);
      end
   endtask

   task automatic take_it();
      irq_ack = 1'b1;
      wt(1);
      irq_ack = 1'b0;
   endtask

   task automatic ret_it();
      irq_ret = 1'b1;
      wt(1);
      irq_ret = 1'b0;
      wt(1);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : main
      rst_n = 1'b0; nmi_n = 1'b1; grpa_pin = '0; grpb_pin = '0;
      tmr_zero = 0; tmr_ie = 0; adc_eoc = 0; adc_ie = 0; gen_en = 0;
      edge_rise = 0; port_to_v2 = 0; irq_ack = 0; irq_ret = 0;
      wt(3);
      expect_req("R1 in reset", 1'b0, 0);
      rst_n = 1'b1;
      wt(5);
      expect_req("R1 after reset", 1'b0, 0);

      // R2: NMI falling edge, independent of gen_en
      nmi_n = 1'b0; wt(5);
      expect_req("R2 nmi", 1'b1, 0);
      take_it();
      expect_req("R8 nmi latch cleared", 1'b0, 0);
      ret_it();
      nmi_n = 1'b1; wt(5);
      expect_req("R2 rising nmi ignored", 1'b0, 0);

      // R3/R4/R5: sweep over group, pin, edge polarity and steering
      for (int g = 0; g < 2; g++)
         for (int p = 0; p < 2; p++)
            for (int r = 0; r < 2; r++)
               for (int v = 0; v < 2; v++) begin
                  automatic int ev = (g == 0) ? (v ? 2 : 1) : 2;
                  gen_en = 0; edge_rise = r[0]; port_to_v2 = v[0];
                  wt(1);
                  if (g == 0) grpa_pin[p] = 1'b1; else grpb_pin[p] = 1'b1;
                  wt(5);
                  expect_req("R3/R4 gen off, no request", 1'b0, 0);
                  if (r == 0) begin
                     gen_en = 1; wt(1);
                     expect_req("R4 rising ignored with falling select", 1'b0, 0);
                     gen_en = 0; wt(1);
                     if (g == 0) grpa_pin[p] = 1'b0; else grpb_pin[p] = 1'b0;
                     wt(5);
                     expect_req("R3 falling latched while gen off", 1'b0, 0);
                  end
                  gen_en = 1; wt(1);
                  expect_req("R3/R5 pending taken on enable", 1'b1, ev);
                  take_it();
                  expect_req("R8 port latch cleared", 1'b0, 0);
                  ret_it();
                  expect_req("R8 no request after return", 1'b0, 0);
                  if (r == 1) begin
                     if (g == 0) grpa_pin[p] = 1'b0; else grpb_pin[p] = 1'b0;
                     wt(5);
                     expect_req("R4 falling ignored with rising select", 1'b0, 0);
                  end
               end

      // R6: level sources need flag and enable
      gen_en = 1;
      for (int t = 0; t < 4; t++) begin
         tmr_zero = t[0]; tmr_ie = t[1]; wt(1);
         expect_req("R6 timer gating", t == 3, 3);
         tmr_zero = 0; tmr_ie = 0;
         adc_eoc = t[0]; adc_ie = t[1]; wt(1);
         expect_req("R6 adc gating", t == 3, 4);
         adc_eoc = 0; adc_ie = 0; wt(1);
      end
      tmr_zero = 1; tmr_ie = 1; gen_en = 0; wt(1);
      expect_req("R6 timer masked by gen_en", 1'b0, 0);
      tmr_zero = 0; tmr_ie = 0;

      // R7: priority over every subset of the five vectors
      for (int m = 1; m < 32; m++) begin
         automatic int rem = m;
         gen_en = 0; edge_rise = 1; port_to_v2 = 0; wt(1);
         if (m[0]) nmi_n = 1'b0;
         if (m[1]) grpa_pin[0] = 1'b1;
         if (m[2]) grpb_pin[0] = 1'b1;
         if (m[3]) begin tmr_zero = 1; tmr_ie = 1; end
         if (m[4]) begin adc_eoc = 1; adc_ie = 1; end
         wt(5);
         gen_en = 1; wt(1);
         while (rem != 0) begin
            automatic int lo = 0;
            while (!rem[lo]) lo++;
            expect_req("R7 priority", 1'b1, lo);
            take_it();
            if (lo == 3) tmr_zero = 0;
            if (lo == 4) adc_eoc = 0;
            ret_it();
            rem = rem & ~(1 << lo);
         end
         expect_req("R7 all served", 1'b0, 0);
         nmi_n = 1'b1; grpa_pin = '0; grpb_pin = '0; tmr_ie = 0; adc_ie = 0;
         wt(5);
         expect_req("R7 restore edges ignored", 1'b0, 0);
      end

      // R9: in-service blocking, NMI preemption, level sources persist
      gen_en = 1; tmr_zero = 1; tmr_ie = 1; wt(1);
      expect_req("R9 timer first", 1'b1, 3);
      take_it();
      adc_eoc = 1; adc_ie = 1; wt(2);
      expect_req("R9 blocked in service", 1'b0, 0);
      nmi_n = 1'b0; wt(5);
      expect_req("R2 nmi during maskable service", 1'b1, 0);
      take_it();
      expect_req("R9 nothing during nmi service", 1'b0, 0);
      nmi_n = 1'b1;
      ret_it();
      expect_req("R9 maskable service still active", 1'b0, 0);
      ret_it();
      expect_req("R8 timer not cleared by controller", 1'b1, 3);
      take_it();
      tmr_zero = 0;
      ret_it();
      expect_req("R9 adc after return", 1'b1, 4);
      take_it();
      adc_eoc = 0;
      ret_it();
      expect_req("R9 idle at end", 1'b0, 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule